// File: doc/BRIEF.md
# Oversampled Sync Word Correlator

The block sits on the hard-decision output of a receiver that delivers eight samples per symbol. Every accepted sample is shifted into a 512-entry buffer. The buffer is then scored against a 64-bit sync word in which each word bit stands for eight consecutive samples. Across a search period the block keeps the best score and the index of the sample that produced it. It raises an active-low match flag once that best score is strictly above a programmable 10-bit threshold. The index of the winning sample serves as the recovered timing phase, with a resolution of one eighth of a bit, so that a slot counter can be realigned.

After the best alignment has been confirmed, the four symbols that follow the sync word are picked up. The block then stops searching until the next search period begins. Three search behaviours are offered. Continuous search lets received data through only once a match exists. Windowed search considers only samples near the half-slot tick and always lets data through. A master-receive behaviour searches everywhere and also always lets data through.

Top module: `sync_correlator`

## Requirements
- R1: After reset, max_score_o and peak_pos_o are 0, match_n_o is 1, trailer_o is 0 and trailer_valid_o is 0. With mode_i = 2'b00, rx_pass_o is 0.
- R2: For each evaluated sample, the score is the number of positions j (0 = newest sample, 511 = oldest) at which the buffered sample equals sync_word_i bit floor(j/8). Sync bit 63 is therefore compared with the eight oldest samples. max_score_o reports the best score seen, saturating at 2^SCORE_W-1.
- R3: max_score_o changes only when a score is strictly greater than it. peak_pos_o is the index of the sample that completed the best window, counted from 0 at the first sample after start_i. On a tie, the earlier sample is kept.
- R4: match_n_o is 0 exactly when max_score_o > threshold_i. When the two are equal, match_n_o is 1.
- R5: With rx_invert_i = 1, each sample is complemented as it enters the buffer. The correlation and the trailer bits both see the complemented value.
- R6: mode_i encodes the search: 2'b00 continuous, 2'b01 windowed, 2'b10 and 2'b11 master receive. In windowed mode, a sample may update the maximum only when its phase p meets p < 624 or p >= 2420. The phase p counts samples since the last tick_i and wraps at 2500. The sample taken in the tick cycle keeps the old phase. In the other modes every sample is eligible.
- R7: The samples that arrive 4, 12, 20 and 28 samples after the peak sample land in trailer_o[0], [1], [2] and [3]. A new peak clears trailer_o. trailer_valid_o rises when the 28th sample after the peak arrives while match_n_o is 0. From then on, max_score_o, peak_pos_o and trailer_o hold until start_i.
- R8: In mode 2'b00, rx_pass_o equals the inverse of match_n_o. In every other mode it is 1.
- R9: start_i clears the maximum, the peak, the trailer, trailer_valid_o and the sample index. A sample whose index is below 511 is never scored, so samples from before start_i cannot produce a match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begins a new search period |
| mode_i | input | 2 | Search behaviour (see R6) |
| rx_invert_i | input | 1 | Complements incoming samples |
| sync_word_i | input | 64 | Sync word, bit 63 received first |
| threshold_i | input | 10 | Match threshold |
| sample_valid_i | input | 1 | A new sample is present |
| sample_i | input | 1 | Hard-decision receive sample |
| tick_i | input | 1 | Half-slot tick, restarts the window phase |
| max_score_o | output | 10 | Best score of the search period |
| peak_pos_o | output | 16 | Index of the sample that gave the best score |
| match_n_o | output | 1 | 0 when the sync word matched |
| trailer_o | output | 4 | Symbols following the sync word |
| trailer_valid_o | output | 1 | Trailer captured; search frozen |
| rx_pass_o | output | 1 | Received data may flow downstream |

## Verification
A new maximum and a trailer pick-up can fall on the same sample. As the alignment approaches a sync word, the score climbs over several adjacent samples, so each of those samples both raises the peak and restarts the trailer count. A directed case adds a stronger, fully correct copy of the sync word sixteen samples after a damaged copy whose score is already above the threshold. The trailer count of the first peak is then cut short by the second. The result is judged by comparing trailer_o, peak_pos_o and trailer_valid_o with a bench model that replays the same stream. In that model a winning sample suppresses the capture and lock step for that sample.

// File: rtl/sync_corr_pkg.sv
package sync_corr_pkg;

   typedef enum logic [1:0] {
      MODE_CONT    = 2'b00,
      MODE_WIN     = 2'b01,
      MODE_MRX     = 2'b10,
      MODE_MRX_ALT = 2'b11
   } rx_mode_e;

   // Sample distance after the peak at which trailer symbol k is taken.
   function automatic int unsigned trail_offset(input int unsigned k,
                                                input int unsigned os);
      return k * os + os / 2;
   endfunction

endpackage

// File: rtl/sync_corr_sample_buf.sv
module sync_corr_sample_buf #(
   parameter int unsigned DEPTH = 512
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             shift_i,
   input  logic             bit_i,
   input  logic             invert_i,
   output logic [DEPTH-1:0] taps_o
);

   if (DEPTH < 2) begin : g_bad_depth
      $error("sample buffer needs at least two entries");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         taps_o <= '0;
      end else if (shift_i) begin
         taps_o <= {taps_o[DEPTH-2:0], bit_i ^ invert_i};
      end
   end

endmodule

// File: rtl/sync_corr_score.sv
module sync_corr_score #(
   parameter int unsigned SYNC_BITS  = 64,
   parameter int unsigned OVERSAMPLE = 8,
   parameter int unsigned SCORE_W    = 10
) (
   input  logic [SYNC_BITS*OVERSAMPLE-1:0] taps_i,
   input  logic [SYNC_BITS-1:0]            word_i,
   output logic [SCORE_W-1:0]              score_o
);

   localparam int unsigned WIN    = SYNC_BITS * OVERSAMPLE;
   localparam int unsigned SYM_W  = $clog2(OVERSAMPLE + 1);
   localparam int unsigned FULL_W = $clog2(WIN + 1);

   logic [SYNC_BITS*SYM_W-1:0] hits_flat;
   logic [FULL_W-1:0]          total;

   // One agreement counter per sync-word bit, over that bit's samples.
   for (genvar b = 0; b < SYNC_BITS; b++) begin : g_sym
      logic [SYM_W-1:0] cnt;
      always_comb begin
         cnt = '0;
         for (int s = 0; s < OVERSAMPLE; s++) begin
            cnt = cnt + SYM_W'(taps_i[b*OVERSAMPLE+s] ~^ word_i[b]);
         end
      end
      assign hits_flat[b*SYM_W +: SYM_W] = cnt;
   end

   always_comb begin
      total = '0;
      for (int b = 0; b < SYNC_BITS; b++) begin
         total = total + FULL_W'(hits_flat[b*SYM_W +: SYM_W]);
      end
   end

   if (FULL_W > SCORE_W) begin : g_sat
      localparam logic [SCORE_W-1:0] SAT = '1;
      assign score_o = (total > FULL_W'(SAT)) ? SAT : total[SCORE_W-1:0];
   end else begin : g_wide
      assign score_o = SCORE_W'(total);
   end

endmodule

// File: rtl/sync_corr_window.sv
module sync_corr_window #(
   parameter int unsigned PERIOD = 2500,
   parameter int unsigned PRE    = 80,
   parameter int unsigned POST   = 624
) (
   input  logic clk,
   input  logic rst_n,
   input  logic windowed_i,
   input  logic tick_i,
   input  logic adv_i,
   output logic open_o
);

   localparam int unsigned PH_W = $clog2(PERIOD);
   localparam logic [PH_W-1:0] LAST     = PH_W'(PERIOD - 1);
   localparam logic [PH_W-1:0] CLOSE_AT = PH_W'(POST);

   logic [PH_W-1:0] phase_q;
   logic            in_win;

   // Reset phase lies in the closed part until the first tick arrives.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= CLOSE_AT;
      end else if (tick_i) begin
         phase_q <= '0;
      end else if (adv_i) begin
         phase_q <= (phase_q == LAST) ? '0 : phase_q + PH_W'(1);
      end
   end

   if (PRE > 0) begin : g_pre
      localparam logic [PH_W-1:0] OPEN_AT = PH_W'(PERIOD - PRE);
      assign in_win = (phase_q < CLOSE_AT) || (phase_q >= OPEN_AT);
   end else begin : g_nopre
      assign in_win = (phase_q < CLOSE_AT);
   end

   assign open_o = !windowed_i || in_win;

endmodule

// File: rtl/sync_corr_peak.sv
module sync_corr_peak
   import sync_corr_pkg::*;
#(
   parameter int unsigned WIN          = 512,
   parameter int unsigned SCORE_W      = 10,
   parameter int unsigned POS_W        = 16,
   parameter int unsigned OVERSAMPLE   = 8,
   parameter int unsigned TRAILER_BITS = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clear_i,
   input  logic                    eval_i,
   input  logic                    eligible_i,
   input  logic [SCORE_W-1:0]      score_i,
   input  logic                    newest_i,
   input  logic [SCORE_W-1:0]      threshold_i,
   output logic [SCORE_W-1:0]      max_o,
   output logic [POS_W-1:0]        pos_o,
   output logic [TRAILER_BITS-1:0] trailer_o,
   output logic                    locked_o
);

   localparam int unsigned SPAN = trail_offset(TRAILER_BITS - 1, OVERSAMPLE);
   localparam int unsigned SP_W = $clog2(SPAN + 2);
   localparam logic [SP_W-1:0]  SP_CAP   = SP_W'(SPAN + 1);
   localparam logic [SP_W-1:0]  SP_LAST  = SP_W'(SPAN);
   localparam logic [POS_W-1:0] READY_AT = POS_W'(WIN - 1);
   localparam logic [POS_W-1:0] IDX_MAX  = '1;

   logic [SCORE_W-1:0]      best_q;
   logic [POS_W-1:0]        pos_q;
   logic [POS_W-1:0]        idx_q;
   logic [SP_W-1:0]         since_q;
   logic [SP_W-1:0]         since_nx;
   logic [TRAILER_BITS-1:0] trail_q;
   logic                    lock_q;
   logic                    matched;
   logic                    take;

   assign matched  = best_q > threshold_i;
   assign take     = eval_i && !lock_q && (idx_q >= READY_AT) && eligible_i
                     && (score_i > best_q);
   assign since_nx = (since_q == SP_CAP) ? SP_CAP : since_q + SP_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         best_q  <= '0;
         pos_q   <= '0;
         idx_q   <= '0;
         since_q <= '0;
         trail_q <= '0;
         lock_q  <= 1'b0;
      end else if (clear_i) begin
         best_q  <= '0;
         pos_q   <= '0;
         idx_q   <= '0;
         since_q <= '0;
         trail_q <= '0;
         lock_q  <= 1'b0;
      end else if (eval_i) begin
         idx_q <= (idx_q == IDX_MAX) ? idx_q : idx_q + POS_W'(1);
         if (take) begin
            best_q  <= score_i;
            pos_q   <= idx_q;
            since_q <= '0;
            trail_q <= '0;
         end else if (!lock_q) begin
            since_q <= since_nx;
            for (int k = 0; k < TRAILER_BITS; k++) begin
               if (since_nx == SP_W'(trail_offset(k, OVERSAMPLE))) begin
                  trail_q[k] <= newest_i;
               end
            end
            if (since_nx == SP_LAST && matched) begin
               lock_q <= 1'b1;
            end
         end
      end
   end

   assign max_o     = best_q;
   assign pos_o     = pos_q;
   assign trailer_o = trail_q;
   assign locked_o  = lock_q;

endmodule

// File: rtl/sync_correlator.sv
module sync_correlator
   import sync_corr_pkg::*;
#(
   parameter int unsigned SYNC_BITS    = 64,
   parameter int unsigned OVERSAMPLE   = 8,
   parameter int unsigned SCORE_W      = 10,
   parameter int unsigned POS_W        = 16,
   parameter int unsigned TRAILER_BITS = 4,
   parameter int unsigned TICK_PERIOD  = 2500,
   parameter int unsigned PRE_SAMPLES  = 80,
   parameter int unsigned POST_SAMPLES = 624
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start_i,
   input  logic [1:0]              mode_i,
   input  logic                    rx_invert_i,
   input  logic [SYNC_BITS-1:0]    sync_word_i,
   input  logic [SCORE_W-1:0]      threshold_i,
   input  logic                    sample_valid_i,
   input  logic                    sample_i,
   input  logic                    tick_i,
   output logic [SCORE_W-1:0]      max_score_o,
   output logic [POS_W-1:0]        peak_pos_o,
   output logic                    match_n_o,
   output logic [TRAILER_BITS-1:0] trailer_o,
   output logic                    trailer_valid_o,
   output logic                    rx_pass_o
);

   localparam int unsigned WIN = SYNC_BITS * OVERSAMPLE;

   if (OVERSAMPLE < 2) begin : g_bad_os
      $error("oversampling factor must be at least 2");
   end
   if ((2 ** POS_W) <= WIN) begin : g_bad_pos
      $error("position counter too narrow for the sample window");
   end
   if (PRE_SAMPLES + POST_SAMPLES >= TICK_PERIOD) begin : g_bad_win
      $error("search window must be shorter than the tick period");
   end
   if (TRAILER_BITS < 1) begin : g_bad_trail
      $error("at least one trailer symbol is required");
   end

   rx_mode_e         mode;
   logic [WIN-1:0]   taps;
   logic [SCORE_W-1:0] score;
   logic             win_open;
   logic             active_q;
   logic             ev_q;
   logic             elig_q;

   assign mode = rx_mode_e'(mode_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         ev_q     <= 1'b0;
         elig_q   <= 1'b0;
      end else begin
         if (start_i) active_q <= 1'b1;
         ev_q   <= sample_valid_i && active_q && !start_i;
         elig_q <= win_open;
      end
   end

   sync_corr_sample_buf #(
      .DEPTH (WIN)
   ) i_buf (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_i  (sample_valid_i),
      .bit_i    (sample_i),
      .invert_i (rx_invert_i),
      .taps_o   (taps)
   );

   sync_corr_score #(
      .SYNC_BITS  (SYNC_BITS),
      .OVERSAMPLE (OVERSAMPLE),
      .SCORE_W    (SCORE_W)
   ) i_score (
      .taps_i  (taps),
      .word_i  (sync_word_i),
      .score_o (score)
   );

   sync_corr_window #(
      .PERIOD (TICK_PERIOD),
      .PRE    (PRE_SAMPLES),
      .POST   (POST_SAMPLES)
   ) i_window (
      .clk        (clk),
      .rst_n      (rst_n),
      .windowed_i (mode == MODE_WIN),
      .tick_i     (tick_i),
      .adv_i      (sample_valid_i),
      .open_o     (win_open)
   );

   sync_corr_peak #(
      .WIN          (WIN),
      .SCORE_W      (SCORE_W),
      .POS_W        (POS_W),
      .OVERSAMPLE   (OVERSAMPLE),
      .TRAILER_BITS (TRAILER_BITS)
   ) i_peak (
      .clk         (clk),
      .rst_n       (rst_n),
      .clear_i     (start_i),
      .eval_i      (ev_q),
      .eligible_i  (elig_q),
      .score_i     (score),
      .newest_i    (taps[0]),
      .threshold_i (threshold_i),
      .max_o       (max_score_o),
      .pos_o       (peak_pos_o),
      .trailer_o   (trailer_o),
      .locked_o    (trailer_valid_o)
   );

   assign match_n_o = !(max_score_o > threshold_i);
   assign rx_pass_o = (mode == MODE_CONT) ? !match_n_o : 1'b1;

endmodule

// File: rtl/sync_corr_checker.sv
module sync_corr_checker #(
   parameter int unsigned SCORE_W      = 10,
   parameter int unsigned POS_W        = 16,
   parameter int unsigned TRAILER_BITS = 4,
   parameter int unsigned WIN          = 512
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    start_i,
   input logic [1:0]              mode_i,
   input logic [SCORE_W-1:0]      max_score_o,
   input logic [POS_W-1:0]        peak_pos_o,
   input logic                    match_n_o,
   input logic [TRAILER_BITS-1:0] trailer_o,
   input logic                    trailer_valid_o,
   input logic                    rx_pass_o
);

   assert_score_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      32'(max_score_o) <= WIN);

   assert_max_monotone_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !start_i |=> (max_score_o >= $past(max_score_o)));

   assert_lock_on_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(trailer_valid_o) |-> !match_n_o);

   assert_lock_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (trailer_valid_o && !start_i) |=> (trailer_valid_o && $stable(max_score_o)
         && $stable(peak_pos_o) && $stable(trailer_o)));

   assert_pass_other_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i != 2'b00) |-> rx_pass_o);

   assert_hold_cont_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 2'b00 && match_n_o) |-> !rx_pass_o);

   assert_start_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (max_score_o == '0 && peak_pos_o == '0 && !trailer_valid_o
         && trailer_o == '0));

endmodule

bind sync_correlator sync_corr_checker #(
   .SCORE_W      (SCORE_W),
   .POS_W        (POS_W),
   .TRAILER_BITS (TRAILER_BITS),
   .WIN          (WIN)
) i_sync_corr_checker (
   .clk             (clk),
   .rst_n           (rst_n),
   .start_i         (start_i),
   .mode_i          (mode_i),
   .max_score_o     (max_score_o),
   .peak_pos_o      (peak_pos_o),
   .match_n_o       (match_n_o),
   .trailer_o       (trailer_o),
   .trailer_valid_o (trailer_valid_o),
   .rx_pass_o       (rx_pass_o)
);

// File: tb/test_sync_correlator.sv
module test_sync_correlator;

   localparam int CLK_PERIOD = 10;
   localparam int OS     = 8;
   localparam int WIN    = 512;
   localparam int PERIOD = 2500;
   localparam int PRE    = 80;
   localparam int POST   = 624;
   localparam int MAXN   = 3200;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        start_i;
   logic [1:0]  mode_i;
   logic        rx_invert_i;
   logic [63:0] sync_word_i;
   logic [9:0]  threshold_i;
   logic        sample_valid_i;
   logic        sample_i;
   logic        tick_i;
   logic [9:0]  max_score_o;
   logic [15:0] peak_pos_o;
   logic        match_n_o;
   logic [3:0]  trailer_o;
   logic        trailer_valid_o;
   logic        rx_pass_o;

   int checks = 0;
   int fails  = 0;

   bit s_arr [0:MAXN-1];
   bit w_arr [0:MAXN-1];

   int       e_max;
   int       e_pos;
   bit [3:0] e_tr;
   bit       e_lock;

   always #(CLK_PERIOD/2) clk = ~clk;

   sync_correlator i_sync_correlator (
      .clk             (clk),
      .rst_n           (rst_n),
      .start_i         (start_i),
      .mode_i          (mode_i),
      .rx_invert_i     (rx_invert_i),
      .sync_word_i     (sync_word_i),
      .threshold_i     (threshold_i),
      .sample_valid_i  (sample_valid_i),
      .sample_i        (sample_i),
      .tick_i          (tick_i),
      .max_score_o     (max_score_o),
      .peak_pos_o      (peak_pos_o),
      .match_n_o       (match_n_o),
      .trailer_o       (trailer_o),
      .trailer_valid_o (trailer_valid_o),
      .rx_pass_o       (rx_pass_o)
   );

   task automatic chk(input int act, input int exp, input string what);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", what, act, exp);
      end
   endtask

   function automatic int score_at(input int i, input bit inv);
      int sc = 0;
      for (int j = 0; j < WIN; j++) begin
         if ((s_arr[i-j] ^ inv) == sync_word_i[j/OS]) sc++;
      end
      return sc;
   endfunction

   // Reference behaviour of one search period, taken from the requirements.
   task automatic model(input int n);
      int sc;
      int sp = 0;
      bit took;
      e_max = 0; e_pos = 0; e_tr = '0; e_lock = 0;
      for (int i = 0; i < n; i++) begin
         if (e_lock) continue;
         took = 0;
         if (i >= WIN-1 && w_arr[i]) begin
            sc = score_at(i, rx_invert_i);
            if (sc > e_max) begin
               e_max = sc; e_pos = i; sp = 0; e_tr = '0; took = 1;
            end
         end
         if (!took) begin
            sp = (sp < 29) ? sp + 1 : 29;
            for (int k = 0; k < 4; k++) begin
               if (sp == k*OS + OS/2) e_tr[k] = s_arr[i] ^ rx_invert_i;
            end
            if (sp == 28 && e_max > int'(threshold_i)) e_lock = 1;
         end
      end
   endtask

   task automatic fill_noise(input int n);
      for (int i = 0; i < n; i++) s_arr[i] = 1'($urandom_range(0, 1));
   endtask

   task automatic put_sync(input int last, input bit inv, input int flips);
      for (int j = 0; j < WIN; j++) s_arr[last-j] = sync_word_i[j/OS] ^ inv;
      for (int f = 0; f < flips; f++) begin
         int j = $urandom_range(0, WIN-1);
         s_arr[last-j] = ~s_arr[last-j];
      end
   endtask

   task automatic run(input int n, input bit gaps, input bit win);
      int p = 0;
      for (int i = 0; i < n; i++) begin
         if (win) begin
            w_arr[i] = (p < POST) || (p >= PERIOD-PRE);
            p = (p + 1) % PERIOD;
         end else begin
            w_arr[i] = 1;
         end
      end
      @(negedge clk) start_i = 1'b1;
      @(negedge clk) start_i = 1'b0;
      if (win) begin
         tick_i = 1'b1;
         @(negedge clk) tick_i = 1'b0;
      end
      for (int i = 0; i < n; i++) begin
         if (gaps && $urandom_range(0, 3) == 0) begin
            sample_valid_i = 1'b0;
            repeat ($urandom_range(1, 2)) @(negedge clk);
         end
         sample_i = s_arr[i];
         sample_valid_i = 1'b1;
         @(negedge clk);
      end
      sample_valid_i = 1'b0;
      repeat (3) @(negedge clk);
      model(n);
      chk(int'(max_score_o), e_max, "R2 max score");
      chk(int'(peak_pos_o), e_pos, "R3 peak position");
      chk(int'(match_n_o), (e_max > int'(threshold_i)) ? 0 : 1, "R4 match flag");
      chk(int'(trailer_o), int'(e_tr), "R7 trailer bits");
      chk(int'(trailer_valid_o), int'(e_lock), "R7 trailer valid");
      chk(int'(rx_pass_o),
          (mode_i != 2'b00 || e_max > int'(threshold_i)) ? 1 : 0, "R8 release");
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      fails++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd20417));
      rst_n = 1'b0; start_i = 1'b0; mode_i = 2'b00; rx_invert_i = 1'b0;
      sync_word_i = 64'h0; threshold_i = 10'd480;
      sample_valid_i = 1'b0; sample_i = 1'b0; tick_i = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(int'(max_score_o), 0, "R1 reset max");
      chk(int'(peak_pos_o), 0, "R1 reset peak");
      chk(int'(match_n_o), 1, "R1 reset match flag");
      chk(int'(trailer_valid_o), 0, "R1 reset trailer valid");
      chk(int'(trailer_o), 0, "R1 reset trailer");
      chk(int'(rx_pass_o), 0, "R1 reset release");

      // R2/R3/R7 directed continuous search with a clean sync word
      sync_word_i = {$urandom, $urandom};
      fill_noise(1200); put_sync(900, 0, 0);
      run(1200, 0, 0);
      chk(int'(max_score_o), 512, "R2 perfect alignment");
      chk(int'(peak_pos_o), 900, "R3 peak at word end");

      // R4 threshold boundary, equality is not a match
      threshold_i = 10'd512; #1;
      chk(int'(match_n_o), 1, "R4 equal to threshold");
      chk(int'(rx_pass_o), 0, "R8 continuous blocked");
      threshold_i = 10'd511; #1;
      chk(int'(match_n_o), 0, "R4 one below threshold");
      chk(int'(rx_pass_o), 1, "R8 continuous released");
      threshold_i = 10'd480;

      // R9 fewer than a full window of samples after start: nothing scored
      fill_noise(400); put_sync(399, 0, 0);
      run(400, 0, 0);
      chk(int'(max_score_o), 0, "R9 stale window not scored");
      // R9 earliest scorable sample
      fill_noise(560); put_sync(511, 0, 0);
      run(560, 1, 0);
      chk(int'(peak_pos_o), 511, "R9 first full window");

      // R3 tie, first occurrence kept
      threshold_i = 10'd1000;
      fill_noise(1400); put_sync(700, 0, 0); put_sync(1300, 0, 0);
      run(1400, 0, 0);
      chk(int'(peak_pos_o), 700, "R3 tie keeps earlier");

      // R5 inverted polarity
      threshold_i = 10'd480; rx_invert_i = 1'b1;
      fill_noise(1100); put_sync(800, 1, 0);
      run(1100, 1, 0);
      chk(int'(max_score_o), 512, "R5 inverted match");
      fill_noise(1100); put_sync(800, 0, 0);
      run(1100, 0, 0);
      chk(int'(match_n_o), 1, "R5 true polarity rejected");
      rx_invert_i = 1'b0;

      // R8 master receive always releases
      threshold_i = 10'd1000; mode_i = 2'b10;
      fill_noise(900);
      run(900, 1, 0);
      chk(int'(rx_pass_o), 1, "R8 master release");
      mode_i = 2'b11;
      run(900, 0, 0);

      // R6 windowed search
      mode_i = 2'b01; threshold_i = 10'd400;
      fill_noise(2000); put_sync(1200, 0, 0);
      run(2000, 0, 1);
      chk(int'(match_n_o), 1, "R6 closed window ignored");
      fill_noise(2490); put_sync(2450, 0, 0);
      run(2490, 0, 1);
      chk(int'(match_n_o), 0, "R6 open before tick");
      fill_noise(700); put_sync(600, 0, 0);
      run(700, 0, 1);
      chk(int'(match_n_o), 0, "R6 open after tick");
      fill_noise(700); put_sync(630, 0, 0);
      run(700, 0, 1);
      chk(int'(match_n_o), 1, "R6 just after close");

      // R3/R7 stronger copy arriving inside the trailer span
      mode_i = 2'b00; threshold_i = 10'd350;
      fill_noise(1100); put_sync(900, 0, 30); put_sync(916, 0, 0);
      run(1100, 0, 0);
      chk(int'(peak_pos_o), 916, "R7 later peak restarts trailer");

      // Random continuous and master runs
      for (int r = 0; r < 8; r++) begin
         int n = $urandom_range(700, 1500);
         sync_word_i = {$urandom, $urandom};
         threshold_i = 10'($urandom_range(380, 500));
         rx_invert_i = 1'($urandom_range(0, 1));
         mode_i = ($urandom_range(0, 1) == 0) ? 2'b00 : 2'b10;
         fill_noise(n);
         if (r != 3) put_sync($urandom_range(520, n - 40), rx_invert_i,
                              $urandom_range(0, 60));
         run(n, 1, 0);
      end

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule